// File: doc/BRIEF.md
# Standby and idle wake sequencer

This block sequences a small SoC between three power states: operating, idle and standby. Software asks for idle or standby with a one-cycle request. In idle only the CPU clock is gated. In standby the run indication drops, the external buses are forced low and the peripherals are held in reset. The PLL or oscillator is switched off unless the external clock is selected and its keep-enabled bit is set.

Only a pending interrupt leaves either low-power state. In idle, a two-flop synchronised interrupt restarts the CPU clock after a short fixed count of system cycles. In standby, the interrupt first passes a deglitcher that samples it on a slow tick derived from a 16.384 kHz real-time oscillator. The block then times a wake delay picked at the standby request. The long delay lets an oscillator or PLL settle. The fast delay is for a PLL with fast wake. The short delay is the same as the idle path and is used when the clock was never stopped. The long and fast delays end on the second boundary of a free-running tick divider after the wake begins, so the delay falls between one and two divider periods. The PLL or oscillator is enabled again as soon as the delay starts. The buses and the peripherals are released in the same cycle that the CPU clock restarts.

Top module: `pwr_wake_seq`

## Requirements
- R1: After reset the block is operating: cpu_clk_en_o=1, osc_en_o=1, run_o=1, bus_low_o=0, periph_rst_o=0.
- R2: A req_idle_i pulse while operating drops cpu_clk_en_o after the next rising edge, with run_o and osc_en_o held at 1 and bus_low_o and periph_rst_o held at 0.
- R3: From idle, with irq_i raised between two edges and held, cpu_clk_en_o is 1 after exactly the 5th following rising edge.
- R4: Only an interrupt wakes the block. Requests of either kind arriving in idle or standby are ignored: in idle run_o stays 1, in standby run_o stays 0, and cpu_clk_en_o stays 0.
- R5: A req_stby_i pulse while operating, which wins over a req_idle_i in the same cycle, gives run_o=0, bus_low_o=1, periph_rst_o=1 and cpu_clk_en_o=0 after the next edge. In that state osc_en_o is 1 only if clk_sel_pll_i=0 and keep_clk_i=1 at the request. With the PLL selected it is always 0.
- R6: In standby, irq_i is accepted only if it is seen high at two consecutive tick_i samples. A pulse shorter than one tick interval never starts a wake.
- R7: With clk_sel_pll_i=1 and fast_wake_i=0, or with clk_sel_pll_i=0 and keep_clk_i=0, the standby wake takes at least 2048 and at most 4100 tick_i pulses, counted from the irq_i rise up to and including the edge where cpu_clk_en_o rises.
- R8: With clk_sel_pll_i=1 and fast_wake_i=1, the standby wake takes between 4 and 12 tick_i pulses, measured the same way.
- R9: With clk_sel_pll_i=0 and keep_clk_i=1, the standby wake takes between 2 and 4 tick_i pulses, measured the same way, and osc_en_o stays 1 throughout.
- R10: On a long or fast standby wake, osc_en_o rises in an earlier cycle than cpu_clk_en_o.
- R11: During a standby wake, run_o=0, bus_low_o=1 and periph_rst_o=1 hold until the cycle in which cpu_clk_en_o rises, and all three change in that cycle.
- R12: Idle or standby requests that arrive during a standby wake are ignored: the block reaches operating and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at the slow real-time tick rate |
| req_idle_i | input | 1 | Software request to enter idle |
| req_stby_i | input | 1 | Software request to enter standby |
| irq_i | input | 1 | Pending-interrupt wake input |
| clk_sel_pll_i | input | 1 | 1: system clock from PLL, 0: external oscillator |
| keep_clk_i | input | 1 | Keep the external clock running in standby |
| fast_wake_i | input | 1 | Select the fast PLL wake delay |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | PLL / oscillator enable |
| run_o | output | 1 | Run indication, low in standby |
| bus_low_o | output | 1 | Force external buses low |
| periph_rst_o | output | 1 | Hold peripherals in reset |

## Verification
The wake path is exercised from idle and from standby, and each clock-source and control-bit combination selects a different delay. The measured tick count separates the long, fast and short delays. The divider phase at the interrupt varies randomly, which shows that the delay stays inside its band at any alignment. A sub-tick interrupt pulse tells the deglitcher apart from a plain synchroniser. Requests placed inside idle, inside standby and inside a running wake show whether the sequencer can be pushed out of order.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [2:0] {
    ST_OPER,
    ST_IDLE,
    ST_IDLE_WAKE,
    ST_STBY,
    ST_STBY_WAKE
  } pws_state_e;

  typedef enum logic [1:0] {
    WK_SHORT,
    WK_FAST,
    WK_LONG
  } wake_kind_e;
endpackage

// File: rtl/pws_irq_filter.sv
module pws_irq_filter #(
  parameter int DG_SAMPLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic irq_i,
  output logic irq_sync_o,
  output logic wake_acc_o
);
  logic [1:0]            sync_q;
  logic [DG_SAMPLES-1:0] dg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      dg_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], irq_i};
      if (tick_i) dg_q <= (dg_q << 1) | DG_SAMPLES'(sync_q[1]);
    end
  end

  assign irq_sync_o = sync_q[1];
  assign wake_acc_o = &dg_q;

  a_r6_accept_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_acc_o) |-> $past(tick_i));
endmodule

// File: rtl/pws_tick_div.sv
module pws_tick_div #(
  parameter int LONG_LOG2 = 11,
  parameter int FAST_LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic long_b_o,
  output logic fast_b_o
);
  logic [LONG_LOG2-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_i) div_q <= div_q + 1'b1;
  end

  assign long_b_o = tick_i & (&div_q);
  assign fast_b_o = tick_i & (&div_q[FAST_LOG2-1:0]);

  a_r8_fast_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_b_o |=> !fast_b_o);
endmodule

// File: rtl/pws_fsm.sv
module pws_fsm
  import pws_pkg::*;
#(
  parameter int SHORT_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_idle_i,
  input  logic req_stby_i,
  input  logic clk_sel_pll_i,
  input  logic keep_clk_i,
  input  logic fast_wake_i,
  input  logic irq_sync_i,
  input  logic wake_acc_i,
  input  logic fast_b_i,
  input  logic long_b_i,
  output logic cpu_clk_en_o,
  output logic osc_en_o,
  output logic run_o,
  output logic bus_low_o,
  output logic periph_rst_o
);
  localparam int CW = (SHORT_CYC > 1) ? $clog2(SHORT_CYC) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(SHORT_CYC - 1);

  pws_state_e state_q, state_d;
  wake_kind_e mode_q, mode_d, kind_sel;
  logic [CW-1:0] cnt_q, cnt_d;
  logic bnd_q, bnd_d, bnd_hit;

  // delay kind is frozen at the standby request
  always_comb begin
    if (clk_sel_pll_i) kind_sel = fast_wake_i ? WK_FAST : WK_LONG;
    else               kind_sel = keep_clk_i ? WK_SHORT : WK_LONG;
  end

  assign bnd_hit = (mode_q == WK_FAST) ? fast_b_i : long_b_i;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    bnd_d   = bnd_q;
    unique case (state_q)
      ST_OPER: begin
        if (req_stby_i) begin
          state_d = ST_STBY;
          mode_d  = kind_sel;
        end else if (req_idle_i) begin
          state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (irq_sync_i) begin
          state_d = ST_IDLE_WAKE;
          cnt_d   = CNT_INIT;
        end
      end
      ST_IDLE_WAKE: begin
        if (cnt_q == '0) state_d = ST_OPER;
        else             cnt_d   = cnt_q - CW'(1);
      end
      ST_STBY: begin
        if (wake_acc_i) begin
          state_d = ST_STBY_WAKE;
          cnt_d   = CNT_INIT;
          bnd_d   = 1'b0;
        end
      end
      ST_STBY_WAKE: begin
        if (mode_q == WK_SHORT) begin
          if (cnt_q == '0) state_d = ST_OPER;
          else             cnt_d   = cnt_q - CW'(1);
        end else if (bnd_hit) begin
          // second divider boundary ends the wait
          if (bnd_q) state_d = ST_OPER;
          else       bnd_d   = 1'b1;
        end
      end
      default: state_d = ST_OPER;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPER;
      mode_q  <= WK_LONG;
      cnt_q   <= '0;
      bnd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      bnd_q   <= bnd_d;
    end
  end

  logic in_stby;
  assign in_stby      = (state_q == ST_STBY) || (state_q == ST_STBY_WAKE);
  assign cpu_clk_en_o = (state_q == ST_OPER);
  assign run_o        = !in_stby;
  assign bus_low_o    = in_stby;
  assign periph_rst_o = in_stby;
  assign osc_en_o     = (state_q != ST_STBY) || (mode_q == WK_SHORT);

  a_r4_idle_needs_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !irq_sync_i) |=> (state_q == ST_IDLE));
  a_r4_stby_needs_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && !wake_acc_i) |=> (state_q == ST_STBY));
  a_r5_pll_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && mode_q != WK_SHORT) |-> !osc_en_o);
  a_r12_wake_no_reentry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY_WAKE) |=> (state_q inside {ST_STBY_WAKE, ST_OPER}));
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq #(
  parameter int LONG_LOG2  = 11,
  parameter int FAST_LOG2  = 2,
  parameter int SHORT_CYC  = 2,
  parameter int DG_SAMPLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic req_idle_i,
  input  logic req_stby_i,
  input  logic irq_i,
  input  logic clk_sel_pll_i,
  input  logic keep_clk_i,
  input  logic fast_wake_i,
  output logic cpu_clk_en_o,
  output logic osc_en_o,
  output logic run_o,
  output logic bus_low_o,
  output logic periph_rst_o
);
  logic irq_sync, wake_acc, long_b, fast_b;

  pws_irq_filter #(.DG_SAMPLES(DG_SAMPLES)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .irq_i(irq_i),
    .irq_sync_o(irq_sync), .wake_acc_o(wake_acc)
  );

  pws_tick_div #(.LONG_LOG2(LONG_LOG2), .FAST_LOG2(FAST_LOG2)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .long_b_o(long_b), .fast_b_o(fast_b)
  );

  pws_fsm #(.SHORT_CYC(SHORT_CYC)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_idle_i(req_idle_i), .req_stby_i(req_stby_i),
    .clk_sel_pll_i(clk_sel_pll_i), .keep_clk_i(keep_clk_i), .fast_wake_i(fast_wake_i),
    .irq_sync_i(irq_sync), .wake_acc_i(wake_acc),
    .fast_b_i(fast_b), .long_b_i(long_b),
    .cpu_clk_en_o(cpu_clk_en_o), .osc_en_o(osc_en_o), .run_o(run_o),
    .bus_low_o(bus_low_o), .periph_rst_o(periph_rst_o)
  );

  a_r11_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> (run_o && !bus_low_o && !periph_rst_o));
endmodule

// File: tb/tb_pwr_wake_seq.sv
module tb_pwr_wake_seq;
  localparam int LN = 2048;
  localparam int M_IDLE = 0, M_LPLL = 1, M_LEXT = 2, M_FAST = 3, M_KEEP = 4;

  logic clk = 0, rst_n = 0, tick = 0;
  logic req_idle = 0, req_stby = 0, irq = 0;
  logic pll_sel = 0, keep = 0, fastw = 0;
  logic cpu_en, osc_en, run, bus_low, prst;

  int n_tests = 0, n_fail = 0;
  int tick_period = 3;
  int tcnt = 0;

  always #4 clk = ~clk;

  pwr_wake_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .req_idle_i(req_idle), .req_stby_i(req_stby), .irq_i(irq),
    .clk_sel_pll_i(pll_sel), .keep_clk_i(keep), .fast_wake_i(fastw),
    .cpu_clk_en_o(cpu_en), .osc_en_o(osc_en), .run_o(run),
    .bus_low_o(bus_low), .periph_rst_o(prst)
  );

  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      if (ph >= tick_period - 1) begin ph = 0; tick = 1; end
      else begin ph++; tick = 0; end
    end
  end

  initial forever begin
    @(posedge clk);
    if (tick) tcnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_lo(input int m);
    case (m)
      M_LPLL, M_LEXT: return LN;
      M_FAST:         return 4;
      default:        return 2;
    endcase
  endfunction

  function automatic int exp_hi(input int m);
    case (m)
      M_LPLL, M_LEXT: return 2 * LN + 4;
      M_FAST:         return 12;
      default:        return 4;
    endcase
  endfunction

  function automatic string mode_req(input int m);
    case (m)
      M_LPLL, M_LEXT: return "R7";
      M_FAST:         return "R8";
      default:        return "R9";
    endcase
  endfunction

  task automatic configure(input int m);
    case (m)
      M_LPLL: begin pll_sel = 1; fastw = 0; keep = 1'($urandom_range(0, 1)); end
      M_LEXT: begin pll_sel = 0; keep = 0; fastw = 1'($urandom_range(0, 1)); end
      M_FAST: begin pll_sel = 1; fastw = 1; keep = 1'($urandom_range(0, 1)); end
      M_KEEP: begin pll_sel = 0; keep = 1; fastw = 1'($urandom_range(0, 1)); end
      default: begin pll_sel = 1'($urandom_range(0, 1)); keep = 1'($urandom_range(0, 1)); end
    endcase
  endtask

  task automatic enter_sleep(input int m, input bit extra);
    @(negedge clk);
    configure(m);
    if (m == M_IDLE) req_idle = 1;
    else begin req_stby = 1; req_idle = extra; end
    @(negedge clk);
    req_idle = 0; req_stby = 0;
    if (m == M_IDLE) begin
      chk(!cpu_en && run && osc_en && !bus_low && !prst, "R2 idle entry", {cpu_en, run, osc_en}, 3'b011);
    end else begin
      chk(!cpu_en && !run && bus_low && prst, "R5 standby outputs", {cpu_en, run, bus_low, prst}, 4'b0011);
      chk(osc_en == (m == M_KEEP), "R5 osc in standby", osc_en, m == M_KEEP);
    end
    repeat ($urandom_range(3, 20)) @(negedge clk);
    if (extra) begin
      if (m == M_IDLE) req_stby = 1; else req_idle = 1;
      @(negedge clk);
      req_stby = 0; req_idle = 0;
      repeat (3) @(negedge clk);
      chk(!cpu_en && run == (m == M_IDLE), "R4 request while asleep ignored", {cpu_en, run}, {1'b0, m == M_IDLE});
    end
  endtask

  task automatic wake(input int m, input bit extra);
    int cyc, osc_cyc;
    bit bad_bus, pulsed, clr;
    cyc = 0; osc_cyc = -1; bad_bus = 0; pulsed = 0; clr = 0;
    irq = 1;
    tcnt = 0;
    while (!cpu_en && cyc < 30000) begin
      @(negedge clk);
      cyc++;
      if (clr) begin req_idle = 0; req_stby = 0; clr = 0; end
      if (!cpu_en && m != M_IDLE) begin
        if (!(!run && bus_low && prst)) bad_bus = 1;
        if (osc_en && osc_cyc < 0) osc_cyc = cyc;
        if (m == M_KEEP && !osc_en) bad_bus = 1;
        if (extra && osc_cyc >= 0 && !pulsed && m != M_KEEP) begin
          req_idle = 1; req_stby = 1; pulsed = 1; clr = 1;
        end
      end
    end
    req_idle = 0; req_stby = 0;
    if (m == M_IDLE) begin
      chk(cyc == 5, "R3 idle wake cycles", cyc, 5);
    end else begin
      chk(tcnt >= exp_lo(m) && tcnt <= exp_hi(m), mode_req(m), tcnt, exp_lo(m));
      chk(!bad_bus, "R11 held during wake", bad_bus, 0);
      chk(run && !bus_low && !prst, "R11 release with clock", {run, bus_low, prst}, 3'b100);
      if (m != M_KEEP) chk(osc_cyc > 0 && osc_cyc < cyc, "R10 osc before clock", osc_cyc, cyc - 1);
    end
    irq = 0;
    repeat (4 * tick_period + 8) @(negedge clk);
    if (extra && m != M_IDLE)
      chk(cpu_en && run, "R12 request in wake ignored", {cpu_en, run}, 2'b11);
  endtask

  task automatic glitch_test();
    int saved;
    saved = tick_period;
    tick_period = 8;
    enter_sleep(M_FAST, 0);
    @(negedge clk);
    while (!tick) @(negedge clk);
    @(negedge clk);
    irq = 1;
    repeat (3) @(negedge clk);
    irq = 0;
    repeat (40) @(negedge clk);
    chk(!cpu_en && !osc_en, "R6 short pulse rejected", {cpu_en, osc_en}, 0);
    wake(M_FAST, 0);
    tick_period = saved;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_en && osc_en && run && !bus_low && !prst, "R1 reset state",
        {cpu_en, osc_en, run, bus_low, prst}, 5'b11100);

    enter_sleep(M_IDLE, 1); wake(M_IDLE, 0);
    enter_sleep(M_LPLL, 1); wake(M_LPLL, 1);
    enter_sleep(M_LEXT, 0); wake(M_LEXT, 0);
    enter_sleep(M_FAST, 1); wake(M_FAST, 1);
    enter_sleep(M_KEEP, 1); wake(M_KEEP, 1);
    glitch_test();

    for (int i = 0; i < 6; i++) begin
      int m;
      bit ex;
      m = $urandom_range(0, 4);
      ex = 1'($urandom_range(0, 1));
      tick_period = $urandom_range(2, 4);
      repeat ($urandom_range(1, 50)) @(negedge clk);
      enter_sleep(m, ex);
      wake(m, ex);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule